// File: doc/BRIEF.md
# Reserved-Opcode No-Operation Sequencer

This block sits beside the instruction decoder of an 8-bit processor core. It deals with every opcode the instruction set leaves undefined, so that no such byte can hang the core or have an effect it should not. When the fetch stage presents an opcode that is not a real instruction, the sequencer claims it. It then runs it as a no-operation whose byte length and clock count depend on the opcode group. It skips the right number of operand bytes by pulsing the program-counter increment once per byte, the opcode byte included. It raises a done strobe in the last clock of the group's count.

One group of three-byte reserved opcodes also makes a throw-away read. The two operand bytes form a little-endian absolute address, low byte first, and the block reads that address in the final clock. The returned data is ignored. The block has no path to the register file or the status flags, so a reserved opcode never changes them. Defined opcodes are left to the main decoder and draw no response.

The fetch unit presents the byte at the current program counter on `fetchByte` in every clock. A clock in which `pcInc` is high consumes that byte.

Top module: `nop_seq`

## Requirements
- R1: In an idle clock where `opValid` is high and `opByte` is a reserved opcode, `claim` and `pcInc` are both high in that same clock (cycle 1 of the sequence).
- R2: Opcodes 02, 22, 42, 62, 82, C2 and E2 take 2 bytes and 2 cycles: `pcInc` is high in cycles 1–2 and `done` is high in cycle 2.
- R3: Opcodes whose low nibble is 3, and opcodes 0B, 1B, 2B, 3B, 4B, 5B, 6B, 7B, 8B, 9B, AB, BB, EB and FB, take 1 byte and 1 cycle: `pcInc` and `done` are both high in cycle 1.
- R4: Opcode 44 takes 2 bytes and 3 cycles: `pcInc` is high in cycles 1–2 and `done` in cycle 3.
- R5: Opcodes 54, D4 and F4 take 2 bytes and 4 cycles: `pcInc` is high in cycles 1–2 and `done` in cycle 4.
- R6: Opcode 5C takes 3 bytes and 8 cycles: `pcInc` is high in cycles 1–3 and `done` in cycle 8.
- R7: Opcodes DC and FC take 3 bytes and 4 cycles. `pcInc` is high in cycles 1–3 and `done` in cycle 4.
  - In cycle 4 `memRd` is high and `memAddr` equals {byte fetched in cycle 3, byte fetched in cycle 2}.
  - `memRd` is never high at any other time.
- R8: Every opcode not listed in R2–R7 is ignored: `claim`, `pcInc`, `done` and `memRd` stay low.
- R9: While a multi-cycle sequence runs, `opValid` is ignored. `claim` stays low, and the sequence keeps its own timing.
- R10: After reset all outputs are low. Once `done` has been high, the block is idle in the next clock and accepts a new opcode there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Opcode strobe from the fetch stage |
| opByte | input | 8 | Opcode presented with the strobe |
| fetchByte | input | 8 | Byte at the current program counter |
| claim | output | 1 | Opcode taken as a reserved no-operation |
| pcInc | output | 1 | Advance the program counter by one byte |
| done | output | 1 | Last cycle of the no-operation |
| memRd | output | 1 | Dummy read request |
| memAddr | output | 16 | Dummy read address |

## Verification
The hardest situation to reach from the ports is an opcode strobe arriving while a long sequence is still running. The ideal case is a strobe that carries another reserved opcode during the eight-cycle 5C run or the dummy-read run. Only such a strobe can show whether the sequencer restarts or stretches its count. The stimulus sweeps all 256 opcodes and then issues random reserved and defined opcodes with random operand bytes. In the later cycles of multi-cycle sequences, it raises the strobe with random opcodes. Instructions run back to back, so each one starts in the clock right after the previous done. Address corners 0000 and FFFF are driven directly.

// File: rtl/nopseq_pkg.sv
package nopseq_pkg;

  localparam int OP_W  = 8;
  localparam int CYC_W = 4;

  typedef struct packed {
    logic             valid;
    logic [CYC_W-1:0] bytes;
    logic [CYC_W-1:0] cycles;
    logic             dummyRd;
  } nopInfo_t;

  typedef struct packed {
    logic capLo;
    logic capHi;
    logic rdEn;
  } dpStrobe_t;

  function automatic nopInfo_t mkInfo(input int b, input int c, input logic d);
    nopInfo_t r;
    r.valid   = 1'b1;
    r.bytes   = CYC_W'(b);
    r.cycles  = CYC_W'(c);
    r.dummyRd = d;
    return r;
  endfunction

  function automatic nopInfo_t classifyOp(input logic [OP_W-1:0] op);
    nopInfo_t r;
    logic [3:0] hiN;
    logic [3:0] loN;
    r   = '0;
    hiN = op[7:4];
    loN = op[3:0];
    case (loN)
      4'h2: if (!hiN[0] && hiN != 4'hA) r = mkInfo(2, 2, 1'b0);
      4'h3: r = mkInfo(1, 1, 1'b0);
      4'h4: begin
        if (op == 8'h44) r = mkInfo(2, 3, 1'b0);
        else if (op == 8'h54 || op == 8'hD4 || op == 8'hF4) r = mkInfo(2, 4, 1'b0);
      end
      4'hB: if (hiN != 4'hC && hiN != 4'hD) r = mkInfo(1, 1, 1'b0);
      4'hC: begin
        if (op == 8'h5C) r = mkInfo(3, 8, 1'b0);
        else if (op == 8'hDC || op == 8'hFC) r = mkInfo(3, 4, 1'b1);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nop_ctrl.sv
module nop_ctrl
  import nopseq_pkg::*;
#(
  parameter int CNT_W = CYC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opByte,
  output logic            claim,
  output logic            pcInc,
  output logic            done,
  output dpStrobe_t       strb
);

  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] SECND = CNT_W'(2);
  localparam logic [CNT_W-1:0] THIRD = CNT_W'(3);

  nopInfo_t info;
  assign info = classifyOp(opByte);

  logic             busy;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] lenB;
  logic [CNT_W-1:0] lenC;
  logic             dumR;

  always_comb begin
    claim = opValid && info.valid && !busy;
    pcInc = 1'b0;
    done  = 1'b0;
    strb  = '0;
    if (busy) begin
      pcInc      = (step <= lenB);
      done       = (step == lenC);
      strb.capLo = dumR && (step == SECND);
      strb.capHi = dumR && (step == THIRD);
      strb.rdEn  = dumR && (step == lenC);
    end else if (claim) begin
      pcInc = 1'b1;
      done  = (CNT_W'(info.cycles) == ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
      lenB <= '0;
      lenC <= '0;
      dumR <= 1'b0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      step <= step + ONE;
    end else if (claim && !done) begin
      busy <= 1'b1;
      step <= SECND;
      lenB <= CNT_W'(info.bytes);
      lenC <= CNT_W'(info.cycles);
      dumR <= info.dummyRd;
    end
  end

endmodule

// File: rtl/nop_dp.sv
module nop_dp
  import nopseq_pkg::*;
#(
  parameter int DATA_W = OP_W,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] fetchByte,
  input  dpStrobe_t         strb,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr
);

  logic [DATA_W-1:0] loB;
  logic [DATA_W-1:0] hiB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loB <= '0;
      hiB <= '0;
    end else begin
      if (strb.capLo) loB <= fetchByte;
      if (strb.capHi) hiB <= fetchByte;
    end
  end

  assign memRd   = strb.rdEn;
  assign memAddr = strb.rdEn ? {hiB, loB} : '0;

endmodule

// File: rtl/nop_seq.sv
module nop_seq
  import nopseq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opByte,
  input  logic [DATA_W-1:0] fetchByte,
  output logic              claim,
  output logic              pcInc,
  output logic              done,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr
);

  dpStrobe_t strb;

  nop_ctrl #(.CNT_W(CYC_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opByte (opByte),
    .claim  (claim),
    .pcInc  (pcInc),
    .done   (done),
    .strb   (strb)
  );

  nop_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fetchByte(fetchByte),
    .strb     (strb),
    .memRd    (memRd),
    .memAddr  (memAddr)
  );

endmodule

// File: rtl/nop_seq_chk.sv
module nop_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [7:0]  opByte,
  input logic [7:0]  fetchByte,
  input logic        claim,
  input logic        pcInc,
  input logic        done,
  input logic        memRd,
  input logic [15:0] memAddr
);

  AST_CLAIM_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> pcInc); // R1

  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    claim && opByte[3:0] == 4'h3 |-> done); // R3

  AST_LONG_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    claim && opByte == 8'h5C |=> pcInc ##1 pcInc ##1 !pcInc); // R6

  AST_LONG_DONE: assert property (@(posedge clk) disable iff (!rstN)
    claim && opByte == 8'h5C |-> ##7 done); // R6

  AST_READ_LAST: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> done); // R7

  AST_READ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> memAddr == {$past(fetchByte), $past(fetchByte, 2)}); // R7

  AST_DEFINED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opByte == 8'hA9 |-> !claim); // R8

  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    claim && opByte == 8'h44 |=> !claim); // R9

  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (pcInc |-> claim)); // R10

endmodule

bind nop_seq nop_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opByte   (opByte),
  .fetchByte(fetchByte),
  .claim    (claim),
  .pcInc    (pcInc),
  .done     (done),
  .memRd    (memRd),
  .memAddr  (memAddr)
);

// File: tb/nop_seq_bench.sv
module nop_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opByte = '0;
  logic [7:0]  fetchByte = '0;
  logic        claim, pcInc, done, memRd;
  logic [15:0] memAddr;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nop_seq u_nop_seq (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .fetchByte(fetchByte), .claim(claim), .pcInc(pcInc), .done(done),
    .memRd(memRd), .memAddr(memAddr)
  );

  // Expected behaviour per opcode: bytes, cycles, dummy read, requirement tag
  function automatic void refOp(input logic [7:0] op, output int nb, output int nc,
                                output bit dr, output string tag);
    nb = 0; nc = 0; dr = 1'b0; tag = "R8";
    if (op inside {8'h02, 8'h22, 8'h42, 8'h62, 8'h82, 8'hC2, 8'hE2}) begin
      nb = 2; nc = 2; tag = "R2";
    end else if (op[3:0] == 4'h3 ||
                 (op[3:0] == 4'hB && (op <= 8'hBB || op >= 8'hEB))) begin
      nb = 1; nc = 1; tag = "R3";
    end else if (op == 8'h44) begin
      nb = 2; nc = 3; tag = "R4";
    end else if (op inside {8'h54, 8'hD4, 8'hF4}) begin
      nb = 2; nc = 4; tag = "R5";
    end else if (op == 8'h5C) begin
      nb = 3; nc = 8; tag = "R6";
    end else if (op inside {8'hDC, 8'hFC}) begin
      nb = 3; nc = 4; dr = 1'b1; tag = "R7";
    end
  endfunction

  task automatic expect1(input string tag, input string what, input logic [15:0] act,
                         input logic [15:0] exp, input logic [7:0] op);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s op=%02h actual=%0h expected=%0h", tag, what, op, act, exp);
    end
  endtask

  task automatic runOp(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                       input bit interfere);
    int nb, nc;
    bit dr;
    string tag;
    int total;
    refOp(op, nb, nc, dr, tag);
    total = (nc == 0) ? 1 : nc;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (k == 1) begin
        opValid = 1'b1; opByte = op; fetchByte = op;
      end else begin
        opValid   = interfere;
        opByte    = interfere ? 8'h03 ^ 8'($urandom_range(0, 1) * 8'h40) : 8'($urandom);
        fetchByte = (k == 2) ? lo : (k == 3) ? hi : 8'($urandom);
      end
      #2;
      expect1((k == 1) ? ((nc == 0) ? "R8" : "R1") : "R9", "claim",
              16'(claim), 16'(k == 1 && nc != 0), op);
      expect1(tag, "pcInc", 16'(pcInc), 16'(nc != 0 && k <= nb), op);
      expect1((k == 1 && nc != 0 && nc != 1) ? "R10" : tag, "done",
              16'(done), 16'(nc != 0 && k == nc), op);
      expect1(tag, "memRd", 16'(memRd), 16'(dr && k == nc), op);
      if (dr && k == nc) expect1("R7", "memAddr", memAddr, {hi, lo}, op);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0C02));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R10 reset state
    expect1("R10", "claim", 16'(claim), 16'd0, 8'h00);
    expect1("R10", "pcInc", 16'(pcInc), 16'd0, 8'h00);
    expect1("R10", "done",  16'(done),  16'd0, 8'h00);
    expect1("R10", "memRd", 16'(memRd), 16'd0, 8'h00);
    // directed sweep of every opcode
    for (int op = 0; op < 256; op++)
      runOp(8'(op), 8'(op) ^ 8'h5A, ~8'(op), op[0]);
    // directed address corners for R7
    runOp(8'hDC, 8'h00, 8'h00, 1'b1);
    runOp(8'hFC, 8'hFF, 8'hFF, 1'b1);
    runOp(8'h5C, 8'h12, 8'h34, 1'b1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      op = ($urandom_range(0, 3) == 0) ? 8'($urandom)
         : ((8'($urandom_range(0, 15)) << 4) | 8'h0C) ^ (($urandom_range(0, 1) == 1) ? 8'h08 : 8'h00);
      runOp(op, 8'($urandom), 8'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        opValid = 1'b0;
        #2;
        expect1("R10", "idle pcInc", 16'(pcInc), 16'd0, 8'h00);
      end
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule